// File: doc/BRIEF.md
# Bipolar Line Code Decoder (AMI / HDB3 / B8ZS)

This block sits behind the receive slicer of a T1/E1 line interface. Each bit time it takes one pulse indication for each rail: a positive-rail mark, a negative-rail mark, both, or neither. From these it produces a single-rail NRZ data bit and a violation flag. The flag is meant to drive a per-channel error counter. The 2-bit mode input selects the line code. In plain AMI mode every mark decodes as a 1. In HDB3 mode the 4-zero substitution codes are removed. In B8ZS mode the 8-zero substitution code is removed.

Symbols move through a fixed look-ahead window of eight bit times. A substitution pattern is recognised when its last pulse arrives, and every inserted pulse is marked for removal while it is still inside the window. For this reason the data latency is the same in every mode. Each stored symbol carries the polarity of the pulse that preceded it. This lets a bipolar violation that does not belong to a recognised pattern be told apart from an inserted one. `bit_en` marks the clock cycles that carry a bit. On other cycles the block holds its state.

Top module: `bipolar_line_decoder`

## Requirements
- R1: The data bit and violation flag for the symbol accepted at an enabled clock edge appear on the outputs after the eighth enabled edge that follows it, in every mode. Until the first symbol has reached that point, both outputs read 0.
- R2: With mode 2'b01 (HDB3), the codes 000V and B00V are decoded as four zeros. V has the same polarity as the pulse before it. B has the opposite polarity to the pulse before it, and V matches B. The removed pulses raise no flag.
- R3: With mode 2'b10 (B8ZS), the code 000VB0VB is decoded as eight zeros. Taking P as the polarity of the pulse before the code, the pulses are P, -P, -P, P. The removed pulses raise no flag.
- R4: With mode 2'b00 or 2'b11 (AMI), no pulse is removed. Every mark is a 1, and a mark with the same polarity as the previous mark is flagged.
- R5: In HDB3 and B8ZS modes, a mark with the same polarity as the previous mark is flagged when it is not part of a recognised code. The first mark after reset is never flagged.
- R6: A zero bit is flagged when it is at least the (N+1)-th consecutive line zero, where N is 3 for HDB3, 7 for B8ZS and 15 for AMI.
- R7: A symbol with marks on both rails decodes as 1 and is flagged. It does not change the polarity reference used for later marks.
- R8: In HDB3 mode, the V pulse of a recognised code is flagged when its polarity equals that of the previous recognised V. The first V after reset is exempt.
- R9: On a cycle with `bit_en` low, the rail inputs are ignored and both outputs hold their values.
- R10: Reset clears all history, and both outputs read 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bit_en | input | 1 | High on cycles that carry one line symbol |
| mode | input | 2 | 00 AMI, 01 HDB3, 10 B8ZS, 11 AMI |
| rx_pos | input | 1 | Positive-rail mark for this bit time |
| rx_neg | input | 1 | Negative-rail mark for this bit time |
| dec_data | output | 1 | Decoded NRZ data bit |
| dec_viol | output | 1 | Violation flag for the decoded bit |

## Verification
Both outputs for a symbol are due exactly eight enabled edges after that symbol is applied. The bench therefore compares the outputs seen after enabled edge j with the expectation for symbol j-8, and for j below 8 it checks that both read 0. Results are sampled at the falling edge after each enabled edge. Idle cycles with random rail values are inserted between symbols, and on each of them the outputs must match the values last sampled. Expected values come from a bench encoder (the decoded data must equal the source bits) and from a bench model of the flag rules. Both run over the whole symbol list before it is driven.

// File: rtl/bld_pkg.sv
package bld_pkg;

  // Look-ahead depth: one B8ZS code spans eight bit times.
  localparam int unsigned LOOKAHEAD = 8;

  typedef enum logic [1:0] {
    MODE_AMI     = 2'b00,
    MODE_HDB3    = 2'b01,
    MODE_B8ZS    = 2'b10,
    MODE_AMI_ALT = 2'b11
  } line_mode_e;

  // One line symbol plus what the decoder has learned about it.
  typedef struct packed {
    logic live;     // written by a real symbol since reset
    logic pos;      // positive-rail mark
    logic neg;      // negative-rail mark
    logic ref_ok;   // a single-rail mark preceded this symbol
    logic ref_pos;  // polarity of that preceding mark
    logic drop;     // inserted pulse, decode as zero
    logic verr;     // substitution V repeated the previous V polarity
  } slot_t;

  function automatic logic is_mark(slot_t s);
    return s.pos ^ s.neg;
  endfunction

  function automatic logic is_space(slot_t s);
    return ~(s.pos | s.neg);
  endfunction

endpackage

// File: rtl/bld_polarity_track.sv
module bld_polarity_track (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_pos,
  input  logic rx_neg,
  input  logic v_hit,
  input  logic v_pos,
  output logic ref_ok,
  output logic ref_pos,
  output logic lastv_ok,
  output logic lastv_pos
);

  logic ref_ok_d, ref_pos_d, lastv_ok_d, lastv_pos_d;

  always_comb begin
    ref_ok_d    = ref_ok;
    ref_pos_d   = ref_pos;
    lastv_ok_d  = lastv_ok;
    lastv_pos_d = lastv_pos;
    if (bit_en) begin
      if (rx_pos ^ rx_neg) begin
        ref_ok_d  = 1'b1;
        ref_pos_d = rx_pos;
      end
      if (v_hit) begin
        lastv_ok_d  = 1'b1;
        lastv_pos_d = v_pos;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_ok    <= 1'b0;
      ref_pos   <= 1'b0;
      lastv_ok  <= 1'b0;
      lastv_pos <= 1'b0;
    end else begin
      ref_ok    <= ref_ok_d;
      ref_pos   <= ref_pos_d;
      lastv_ok  <= lastv_ok_d;
      lastv_pos <= lastv_pos_d;
    end
  end

endmodule

// File: rtl/bld_subst_detect.sv
module bld_subst_detect
  import bld_pkg::*;
(
  input  line_mode_e                 mode,
  input  slot_t                      cur,
  input  slot_t [LOOKAHEAD-2:0]      win,
  output logic  [LOOKAHEAD-1:0]      drop_mask,
  output logic                       v_hit,
  output logic                       v_pos
);

  // win[k] holds the symbol that arrived k+1 bit times before cur.
  // drop_mask[0] marks cur, drop_mask[k+1] marks win[k].
  logic hdb_plain, hdb_bal, b8_hit;

  always_comb begin
    hdb_plain = is_space(win[2]) & is_space(win[1]) & is_space(win[0]) &
                is_mark(cur) & cur.ref_ok & (cur.pos == cur.ref_pos);

    hdb_bal   = is_mark(win[2]) & ~win[2].drop & win[2].ref_ok &
                (win[2].pos != win[2].ref_pos) &
                is_space(win[1]) & is_space(win[0]) &
                is_mark(cur) & (cur.pos == win[2].pos);

    b8_hit    = is_space(win[6]) & is_space(win[5]) & is_space(win[4]) &
                is_mark(win[3]) & win[3].ref_ok & (win[3].pos == win[3].ref_pos) &
                is_mark(win[2]) & (win[2].pos != win[3].pos) &
                is_space(win[1]) &
                is_mark(win[0]) & (win[0].pos == win[2].pos) &
                is_mark(cur) & (cur.pos == win[3].pos);

    if (mode != MODE_HDB3) begin
      hdb_plain = 1'b0;
      hdb_bal   = 1'b0;
    end
    if (mode != MODE_B8ZS) begin
      b8_hit = 1'b0;
    end

    drop_mask = '0;
    if (hdb_plain) drop_mask[3:0] = 4'b1111;
    if (hdb_bal) begin
      drop_mask[0] = 1'b1;
      drop_mask[3] = 1'b1;
    end
    if (b8_hit) begin
      drop_mask[0] = 1'b1;
      drop_mask[1] = 1'b1;
      drop_mask[3] = 1'b1;
      drop_mask[4] = 1'b1;
    end

    v_hit = hdb_plain | hdb_bal;
    v_pos = cur.pos;
  end

endmodule

// File: rtl/bld_window.sv
module bld_window
  import bld_pkg::*;
#(
  parameter int unsigned DEPTH = LOOKAHEAD
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  slot_t                head,
  input  logic  [DEPTH-1:0]    drop_mask,
  output slot_t [DEPTH-1:0]    stages
);

  slot_t [DEPTH-1:0] stg_q, stg_d;

  always_comb begin
    stg_d = stg_q;
    if (bit_en) begin
      stg_d = {stg_q[DEPTH-2:0], head};
      for (int i = 0; i < DEPTH; i++) begin
        stg_d[i].drop = stg_d[i].drop | drop_mask[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign stages = stg_q;

endmodule

// File: rtl/bld_out_stage.sv
module bld_out_stage
  import bld_pkg::*;
#(
  parameter int unsigned RUN_W      = 5,
  parameter int unsigned AMI_ZMAX   = 15,
  parameter int unsigned HDB3_ZMAX  = 3,
  parameter int unsigned B8ZS_ZMAX  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  line_mode_e mode,
  input  slot_t      exit_slot,
  output logic       dec_data,
  output logic       dec_viol
);

  localparam logic [RUN_W-1:0] RUN_TOP = '1;

  logic [RUN_W-1:0] run_q, run_d, zmax;
  logic data_d, viol_d;
  logic space, mark, pol_err, run_err;

  always_comb begin
    case (mode)
      MODE_HDB3: zmax = RUN_W'(HDB3_ZMAX);
      MODE_B8ZS: zmax = RUN_W'(B8ZS_ZMAX);
      default:   zmax = RUN_W'(AMI_ZMAX);
    endcase
    space   = is_space(exit_slot);
    mark    = is_mark(exit_slot);
    pol_err = mark & exit_slot.ref_ok & (exit_slot.pos == exit_slot.ref_pos);
    run_err = space & (run_q >= zmax);

    data_d = dec_data;
    viol_d = dec_viol;
    run_d  = run_q;
    if (bit_en) begin
      if (exit_slot.live) begin
        data_d = ~exit_slot.drop & (exit_slot.pos | exit_slot.neg);
        viol_d = exit_slot.verr | run_err |
                 (~exit_slot.drop & ((exit_slot.pos & exit_slot.neg) | pol_err));
        if (!space)                run_d = '0;
        else if (run_q != RUN_TOP) run_d = run_q + 1'b1;
      end else begin
        data_d = 1'b0;
        viol_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      dec_data <= 1'b0;
      dec_viol <= 1'b0;
    end else begin
      run_q    <= run_d;
      dec_data <= data_d;
      dec_viol <= viol_d;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(dec_data) && $stable(dec_viol))); // R9

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && exit_slot.live && exit_slot.drop) |=> !dec_data); // R2

  AST_BOTH_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && exit_slot.live && exit_slot.pos && exit_slot.neg) |=> (dec_data && dec_viol)); // R7

endmodule

// File: rtl/bipolar_line_decoder.sv
module bipolar_line_decoder
  import bld_pkg::*;
#(
  parameter int unsigned RUN_W     = 5,
  parameter int unsigned AMI_ZMAX  = 15,
  parameter int unsigned HDB3_ZMAX = 3,
  parameter int unsigned B8ZS_ZMAX = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic [1:0] mode,
  input  logic       rx_pos,
  input  logic       rx_neg,
  output logic       dec_data,
  output logic       dec_viol
);

  line_mode_e mode_e;
  logic ref_ok, ref_pos, lastv_ok, lastv_pos;
  logic v_hit, v_pos;
  logic [LOOKAHEAD-1:0] drop_mask;
  slot_t cur_slot;
  slot_t [LOOKAHEAD-1:0] win;

  assign mode_e = line_mode_e'(mode);

  always_comb begin
    cur_slot.live    = 1'b1;
    cur_slot.pos     = rx_pos;
    cur_slot.neg     = rx_neg;
    cur_slot.ref_ok  = ref_ok;
    cur_slot.ref_pos = ref_pos;
    cur_slot.drop    = 1'b0;
    cur_slot.verr    = v_hit & lastv_ok & (lastv_pos == v_pos);
  end

  bld_polarity_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .rx_pos    (rx_pos),
    .rx_neg    (rx_neg),
    .v_hit     (v_hit),
    .v_pos     (v_pos),
    .ref_ok    (ref_ok),
    .ref_pos   (ref_pos),
    .lastv_ok  (lastv_ok),
    .lastv_pos (lastv_pos)
  );

  bld_subst_detect u_detect (
    .mode      (mode_e),
    .cur       (cur_slot),
    .win       (win[LOOKAHEAD-2:0]),
    .drop_mask (drop_mask),
    .v_hit     (v_hit),
    .v_pos     (v_pos)
  );

  bld_window #(.DEPTH(LOOKAHEAD)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .head      (cur_slot),
    .drop_mask (drop_mask),
    .stages    (win)
  );

  bld_out_stage #(
    .RUN_W     (RUN_W),
    .AMI_ZMAX  (AMI_ZMAX),
    .HDB3_ZMAX (HDB3_ZMAX),
    .B8ZS_ZMAX (B8ZS_ZMAX)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .mode      (mode_e),
    .exit_slot (win[LOOKAHEAD-1]),
    .dec_data  (dec_data),
    .dec_viol  (dec_viol)
  );

  AST_AMI_KEEPS_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && (mode_e == MODE_AMI || mode_e == MODE_AMI_ALT)) |-> (drop_mask == '0)); // R4

  AST_VERR_HDB3_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && cur_slot.verr) |-> (mode_e == MODE_HDB3)); // R8

  AST_ONE_CODE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && (mode_e == MODE_B8ZS)) |-> !v_hit); // R3

endmodule

// File: tb/bipolar_line_decoder_tb_top.sv
`timescale 1ns/1ps
module bipolar_line_decoder_tb_top;

  localparam int MAXN = 1024;
  localparam int LAT  = 8;

  logic clk = 1'b0;
  logic rst_n, bit_en, rx_pos, rx_neg;
  logic [1:0] mode;
  logic dec_data, dec_viol;

  int checks = 0;
  int failures = 0;
  int nsym;
  bit sp [MAXN];
  bit sn [MAXN];
  bit src [MAXN];
  bit ed [MAXN];
  bit ev [MAXN];

  always #4 clk = ~clk;

  bipolar_line_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mode(mode),
    .rx_pos(rx_pos), .rx_neg(rx_neg), .dec_data(dec_data), .dec_viol(dec_viol)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // +1 positive mark, -1 negative mark, 2 both rails, 0 space
  task automatic push(int v);
    sp[nsym] = (v == 1) || (v == 2);
    sn[nsym] = (v == -1) || (v == 2);
    nsym++;
  endtask

  function automatic bit mk(int k);
    return (k >= 0) && (sp[k] ^ sn[k]);
  endfunction

  function automatic bit zr(int k);
    return (k < 0) || (!sp[k] && !sn[k]);
  endfunction

  // Expected outputs from the flag and removal rules.
  task automatic build_expect(int md);
    bit rv [MAXN];
    bit rp [MAXN];
    bit kl [MAXN];
    bit se [MAXN];
    bit refv = 0, refp = 0, lvv = 0, lvp = 0;
    int run = 0;
    int thr = (md == 1) ? 3 : (md == 2) ? 7 : 15;
    for (int i = 0; i < nsym; i++) begin
      bit ha = 0, hb = 0, h8 = 0;
      rv[i] = refv; rp[i] = refp; kl[i] = 0; se[i] = 0;
      if (md == 1 && i >= 3) begin
        ha = zr(i-3) && zr(i-2) && zr(i-1) && mk(i) && rv[i] && (sp[i] == rp[i]);
        hb = mk(i-3) && !kl[i-3] && rv[i-3] && (sp[i-3] != rp[i-3]) &&
             zr(i-2) && zr(i-1) && mk(i) && (sp[i] == sp[i-3]);
      end
      if (md == 2 && i >= 7) begin
        h8 = zr(i-7) && zr(i-6) && zr(i-5) && mk(i-4) && rv[i-4] && (sp[i-4] == rp[i-4]) &&
             mk(i-3) && (sp[i-3] != sp[i-4]) && zr(i-2) && mk(i-1) && (sp[i-1] == sp[i-3]) &&
             mk(i) && (sp[i] == sp[i-4]);
      end
      if (ha) for (int k = i-3; k <= i; k++) kl[k] = 1;
      if (hb) begin kl[i-3] = 1; kl[i] = 1; end
      if (h8) begin kl[i-4] = 1; kl[i-3] = 1; kl[i-1] = 1; kl[i] = 1; end
      if (ha || hb) begin
        if (lvv && (sp[i] == lvp)) se[i] = 1;
        lvv = 1; lvp = sp[i];
      end
      if (mk(i)) begin refv = 1; refp = sp[i]; end
    end
    for (int i = 0; i < nsym; i++) begin
      bit z = zr(i);
      ed[i] = !kl[i] && (sp[i] || sn[i]);
      ev[i] = se[i] || (z && run >= thr) ||
              (!kl[i] && ((sp[i] && sn[i]) || (mk(i) && rv[i] && (sp[i] == rp[i]))));
      run = z ? ((run < 31) ? run + 1 : 31) : 0;
    end
  endtask

  // Line encoder for source bits src[0..n-1].
  task automatic encode(int n, int md);
    bit lp = 0;
    int pc = 0, zc = 0;
    nsym = n;
    for (int i = 0; i < n; i++) begin
      if (src[i]) begin
        sp[i] = !lp; sn[i] = lp; lp = !lp; pc++; zc = 0;
      end else begin
        sp[i] = 0; sn[i] = 0; zc++;
        if (md == 1 && zc == 4) begin
          if (pc % 2 == 1) begin
            sp[i] = lp; sn[i] = !lp;
          end else begin
            sp[i-3] = !lp; sn[i-3] = lp;
            sp[i] = !lp; sn[i] = lp;
            lp = !lp;
          end
          pc = 0; zc = 0;
        end
        if (md == 2 && zc == 8) begin
          sp[i-4] = lp;  sn[i-4] = !lp;
          sp[i-3] = !lp; sn[i-3] = lp;
          sp[i-1] = !lp; sn[i-1] = lp;
          sp[i]   = lp;  sn[i]   = !lp;
          zc = 0;
        end
      end
    end
  endtask

  task automatic run_seg(int md, bit use_src, string tag);
    bit last_d, last_v;
    rst_n = 0; bit_en = 0; rx_pos = 0; rx_neg = 0; mode = md[1:0];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(dec_data == 0 && dec_viol == 0, "R10", "outputs after reset", {dec_data, dec_viol}, 0);
    build_expect(md);
    for (int j = 0; j < nsym + LAT; j++) begin
      rx_pos = (j < nsym) ? sp[j] : 1'b0;
      rx_neg = (j < nsym) ? sn[j] : 1'b0;
      bit_en = 1;
      @(negedge clk);
      bit_en = 0;
      if (j < LAT) begin
        chk(dec_data == 0 && dec_viol == 0, "R1", "before latency", {dec_data, dec_viol}, 0);
      end else begin
        int k = j - LAT;
        bit xd = use_src ? src[k] : ed[k];
        bit xv = (use_src && md != 0) ? 1'b0 : ev[k];
        chk(dec_data == xd && dec_viol == xv, tag, $sformatf("bit %0d {data,viol}", k),
            {dec_data, dec_viol}, {xd, xv});
      end
      last_d = dec_data; last_v = dec_viol;
      if ($urandom % 4 == 0) begin
        repeat (1 + $urandom % 2) begin
          rx_pos = 1'($urandom); rx_neg = 1'($urandom);
          @(negedge clk);
          chk(dec_data == last_d && dec_viol == last_v, "R9", "idle hold",
              {dec_data, dec_viol}, {last_d, last_v});
        end
      end
    end
  endtask

  task automatic clean_seg(int md, int n, string tag);
    for (int i = 0; i < n; i++) src[i] = (i < 2) ? 1'b1 : ($urandom % 100 < 40);
    encode(n, md);
    run_seg(md, 1, tag);
  endtask

  task automatic raw_seg(int md, int n, string tag);
    nsym = 0;
    for (int i = 0; i < n; i++) begin
      int r = $urandom % 20;
      push(r < 10 ? 0 : r < 14 ? 1 : r < 18 ? -1 : 2);
    end
    run_seg(md, 0, tag);
  endtask

  task automatic list_seg(int md, string tag, int q[$]);
    nsym = 0;
    foreach (q[i]) push(q[i]);
    run_seg(md, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // directed corners
    list_seg(1, "R2", '{1,0,0,0,1,-1,0,0,0,-1,1,0,0,1,-1,0});
    list_seg(1, "R8", '{1,0,0,0,1,-1,1,0,0,0,1,-1});
    list_seg(1, "R6", '{1,0,0,0,0,0,-1,1});
    list_seg(1, "R7", '{1,2,-1,0,1,2,2,-1});
    list_seg(1, "R5", '{1,1,-1,-1,0,1,0,1});
    list_seg(0, "R4", '{1,0,0,0,1,-1,0,0,-1,1});
    list_seg(0, "R6", '{1,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,0,-1});
    list_seg(2, "R3", '{1,0,0,0,1,-1,0,-1,1,-1,1});
    list_seg(2, "R5", '{1,0,0,0,1,-1,0,1,-1,1,-1});
    list_seg(2, "R6", '{1,0,0,0,0,0,0,0,0,-1});
    list_seg(3, "R4", '{-1,0,0,0,-1,1,1});
    // random encoded data, decoded bits must equal the source
    clean_seg(1, 300, "R2");
    clean_seg(2, 300, "R3");
    clean_seg(0, 300, "R4");
    // random raw symbols against the rule model
    raw_seg(1, 200, "R5");
    raw_seg(2, 200, "R5");
    raw_seg(0, 200, "R4");
    raw_seg(3, 120, "R4");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule